// File: doc/BRIEF.md
# Stepped 64-bit System Timer with Alarm

This block keeps a 64-bit count that only moves upward. On every cycle where the `tick_en` input is high, the count grows by a programmable step. Two step fields exist, one for each clock source, and the `src_sel` input picks which one applies. Software reaches the block through a flat register port. A write takes one cycle on `wr_en`, `addr` and `wdata`. Reads are combinational on `rdata` for the current `addr`.

A new count is loaded in two phases: software stages a low and a high word, then writes an apply bit. Reading the count also goes through a snapshot. An update request copies the live count into two frozen read-back words, and a valid flag tells software when the copy is ready. A snapshot state machine drives that handshake. Its states are SNAP_EMPTY (no copy yet), SNAP_CAPTURE (copy pending) and SNAP_HELD (copy valid). A request moves any state to SNAP_CAPTURE. SNAP_CAPTURE moves to SNAP_HELD on the next clock. SNAP_HELD stays where it is until the next request.

One 64-bit alarm value is compared with the count on every advancing tick. When the count crosses the alarm value, a raw interrupt flag is set. That flag drives `irq`, gated by an enable bit, either as a single-cycle pulse (edge mode) or as a held level (level mode).

Top module: `stepped_timer`

Register map (word address on `addr`):

| Address | Access | Contents |
|---|---|---|
| 0x0 | read/write | control: bit0 alarm enable, bit1 interrupt mode (1 = level, 0 = edge), bit2 interrupt enable |
| 0x1 | read/write | steps: bits 7:0 step for `src_sel`=0, bits 15:8 step for `src_sel`=1 |
| 0x2 / 0x3 | read/write | staged load value, low / high word |
| 0x4 | write | bit0 = 1 applies the staged value; reads return 0 |
| 0x5 | write / read | write bit0 = 1 requests a snapshot; read bit0 = snapshot valid |
| 0x6 / 0x7 | read | snapshot, low / high word |
| 0x8 / 0x9 | read/write | alarm value, low / high word |
| 0xA | read / write-1-to-clear | bit0 = raw alarm flag |

## Requirements
- R1: After reset the count is 0, the steps are 1 (`src_sel`=0) and 2 (`src_sel`=1), control is 0, the snapshot valid bit reads 0, the raw flag reads 0 and `irq` is low.
- R2: On each clock edge with `tick_en` high and no load pending, the count grows by bits 7:0 of register 0x1 when `src_sel`=0 and by bits 15:8 when `src_sel`=1. With `tick_en` low the count holds.
- R3: Writing 1 to bit0 of 0x4 loads the words staged in 0x2 (low) and 0x3 (high) on the following clock edge. On that edge the load takes priority over a tick. The apply request clears itself after one cycle.
- R4: Writing 1 to bit0 of 0x5 clears the valid bit (0x5 bit0) for one cycle, and the valid bit rises on the edge after that. On that rising edge, 0x6/0x7 take the count as it stood in the cycle after the request. They then stay frozen until the next request.
- R5: With control bit0 set, the raw flag is set on the advancing tick where the count moves from below the alarm value (0x9:0x8) to at least the alarm value. This holds even when the step jumps over the exact alarm value.
- R6: With control bit0 clear, the raw flag is never set by the count.
- R7: The raw flag reads at 0xA bit0 whatever the interrupt enable is. Writing 1 to that bit clears it, and a set in the same cycle wins over the clear.
- R8: In level mode (control bit1 = 1), `irq` equals the raw flag ANDed with control bit2.
- R9: In edge mode (control bit1 = 0), `irq` is high only in the single cycle after the edge that set the raw flag, and only when control bit2 is set.
- R10: Registers 0x0, 0x1, 0x2, 0x3, 0x8 and 0x9 read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| tick_en | input | 1 | advance the count on this edge |
| src_sel | input | 1 | selects which step field applies (0 or 1) |
| wr_en | input | 1 | register write strobe |
| addr | input | 4 | register word address |
| wdata | input | 32 | write data |
| rdata | output | 32 | read data for `addr`, combinational |
| irq | output | 1 | alarm interrupt |

## Verification
A write sampled at clock edge k takes effect on registers and the raw-flag clear right after edge k. A staged load reaches the count after edge k+1. A snapshot request shows valid low after edge k and valid high with frozen data after edge k+1. An alarm crossing on edge k sets the raw flag and `irq` right after that edge, and an edge-mode pulse falls after edge k+1. The bench holds a behavioural model that it advances on every rising edge from the same sampled inputs. On every falling edge it compares `rdata` and `irq` with that model, so each result is checked in exactly the cycle it is due, never earlier or later.

// File: rtl/stimer_pkg.sv
package stimer_pkg;

    typedef enum logic [3:0] {
        A_CTRL    = 4'h0,
        A_STEP    = 4'h1,
        A_STG_LO  = 4'h2,
        A_STG_HI  = 4'h3,
        A_APPLY   = 4'h4,
        A_SNAP    = 4'h5,
        A_SNAP_LO = 4'h6,
        A_SNAP_HI = 4'h7,
        A_ALM_LO  = 4'h8,
        A_ALM_HI  = 4'h9,
        A_IRQ     = 4'hA
    } reg_addr_e;

    typedef enum logic [1:0] {
        SNAP_EMPTY,
        SNAP_CAPTURE,
        SNAP_HELD
    } snap_state_e;

endpackage

// File: rtl/stimer_counter.sv
module stimer_counter #(
    parameter int CNT_W  = 64,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              src_sel,
    input  logic              apply,
    input  logic [CNT_W-1:0]  load_val,
    input  logic [STEP_W-1:0] step_a,
    input  logic [STEP_W-1:0] step_b,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  count_nxt,
    output logic              adv
);
    localparam int PAD_W = CNT_W - STEP_W;

    logic [STEP_W-1:0] step_sel;

    always_comb begin
        step_sel  = src_sel ? step_b : step_a;
        count_nxt = count + {{PAD_W{1'b0}}, step_sel};
        adv       = tick_en && !apply;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count <= '0;
        else if (apply)   count <= load_val;
        else if (tick_en) count <= count_nxt;
    end

    a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> count == $past(load_val));
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!apply && !tick_en) |=> $stable(count));
endmodule

// File: rtl/stimer_snapshot.sv
module stimer_snapshot
    import stimer_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] count,
    output logic             valid,
    output logic [CNT_W-1:0] snap
);
    snap_state_e state, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SNAP_EMPTY;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            SNAP_EMPTY:   state_n = req ? SNAP_CAPTURE : SNAP_EMPTY;
            SNAP_CAPTURE: state_n = req ? SNAP_CAPTURE : SNAP_HELD;
            SNAP_HELD:    state_n = req ? SNAP_CAPTURE : SNAP_HELD;
            default:      state_n = SNAP_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     snap <= '0;
        else if (state == SNAP_CAPTURE) snap <= count;
    end

    assign valid = (state == SNAP_HELD);

    a_r4_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !valid);
    a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !req) |=> (valid && $stable(snap)));
endmodule

// File: rtl/stimer_alarm.sv
module stimer_alarm #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alm_en,
    input  logic             level_mode,
    input  logic             irq_en,
    input  logic             adv,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] count_nxt,
    input  logic [CNT_W-1:0] alarm,
    input  logic             clr,
    output logic             raw,
    output logic             irq
);
    logic hit_evt;
    logic hit_q;

    assign hit_evt = alm_en && adv && (count < alarm) && (count_nxt >= alarm);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw   <= 1'b0;
            hit_q <= 1'b0;
        end else begin
            hit_q <= hit_evt;
            if (hit_evt)  raw <= 1'b1;
            else if (clr) raw <= 1'b0;
        end
    end

    assign irq = irq_en && (level_mode ? raw : hit_q);

    a_r5_raw_on_cross: assert property (@(posedge clk) disable iff (!rst_n)
        hit_evt |=> raw);
    a_r6_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !alm_en |=> !hit_q);
    a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit_evt) |=> !raw);
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |=> !hit_q);
endmodule

// File: rtl/stepped_timer.sv
module stepped_timer
    import stimer_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int STEP_W        = 8,
    parameter int STEP_A_RESET  = 1,
    parameter int STEP_B_RESET  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              src_sel,
    input  logic              wr_en,
    input  logic [3:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int CNT_W  = 2 * DATA_W;
    localparam int CTRL_W = 3;

    logic [CTRL_W-1:0] ctrl_q;
    logic [STEP_W-1:0] step_a_q, step_b_q;
    logic [DATA_W-1:0] stg_lo_q, stg_hi_q, alm_lo_q, alm_hi_q;
    logic              apply_q;
    logic [CNT_W-1:0]  count, count_nxt, snap;
    logic              adv, snap_valid, raw;

    logic wr_apply, wr_snap, wr_clr;
    assign wr_apply = wr_en && (addr == A_APPLY) && wdata[0];
    assign wr_snap  = wr_en && (addr == A_SNAP)  && wdata[0];
    assign wr_clr   = wr_en && (addr == A_IRQ)   && wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            step_a_q <= STEP_W'(STEP_A_RESET);
            step_b_q <= STEP_W'(STEP_B_RESET);
            stg_lo_q <= '0;
            stg_hi_q <= '0;
            alm_lo_q <= '0;
            alm_hi_q <= '0;
            apply_q  <= 1'b0;
        end else begin
            apply_q <= wr_apply;
            if (wr_en) begin
                case (addr)
                    A_CTRL:   ctrl_q   <= wdata[CTRL_W-1:0];
                    A_STEP: begin
                        step_a_q <= wdata[STEP_W-1:0];
                        step_b_q <= wdata[2*STEP_W-1:STEP_W];
                    end
                    A_STG_LO: stg_lo_q <= wdata;
                    A_STG_HI: stg_hi_q <= wdata;
                    A_ALM_LO: alm_lo_q <= wdata;
                    A_ALM_HI: alm_hi_q <= wdata;
                    default: ;
                endcase
            end
        end
    end

    a_r3_apply_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_q && !wr_apply) |=> !apply_q);

    stimer_counter #(.CNT_W(CNT_W), .STEP_W(STEP_W)) i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .src_sel  (src_sel),
        .apply    (apply_q),
        .load_val ({stg_hi_q, stg_lo_q}),
        .step_a   (step_a_q),
        .step_b   (step_b_q),
        .count    (count),
        .count_nxt(count_nxt),
        .adv      (adv)
    );

    stimer_snapshot #(.CNT_W(CNT_W)) i_snapshot (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (wr_snap),
        .count(count),
        .valid(snap_valid),
        .snap (snap)
    );

    stimer_alarm #(.CNT_W(CNT_W)) i_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .alm_en    (ctrl_q[0]),
        .level_mode(ctrl_q[1]),
        .irq_en    (ctrl_q[2]),
        .adv       (adv),
        .count     (count),
        .count_nxt (count_nxt),
        .alarm     ({alm_hi_q, alm_lo_q}),
        .clr       (wr_clr),
        .raw       (raw),
        .irq       (irq)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:    rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            A_STEP:    rdata = {{(DATA_W-2*STEP_W){1'b0}}, step_b_q, step_a_q};
            A_STG_LO:  rdata = stg_lo_q;
            A_STG_HI:  rdata = stg_hi_q;
            A_SNAP:    rdata = {{(DATA_W-1){1'b0}}, snap_valid};
            A_SNAP_LO: rdata = snap[DATA_W-1:0];
            A_SNAP_HI: rdata = snap[CNT_W-1:DATA_W];
            A_ALM_LO:  rdata = alm_lo_q;
            A_ALM_HI:  rdata = alm_hi_q;
            A_IRQ:     rdata = {{(DATA_W-1){1'b0}}, raw};
            default:   rdata = '0;
        endcase
    end
endmodule

// File: tb/test_stepped_timer.sv
module test_stepped_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        src_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";
    bit    done = 1'b0;

    stepped_timer i_stepped_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .src_sel(src_sel),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    bit [63:0] m_cnt, m_snap, m_alm, m_old, m_nxt, m_stepv;
    bit [31:0] m_sl, m_sh, m_al, m_ah;
    bit [7:0]  m_sa, m_sb;
    bit [2:0]  m_ctrl;
    bit        m_apply, m_raw, m_hit, m_adv, m_cross;
    int        m_sst;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_snap = 0; m_sl = 0; m_sh = 0; m_al = 0; m_ah = 0;
            m_sa = 1; m_sb = 2; m_ctrl = 0; m_apply = 0; m_raw = 0;
            m_hit = 0; m_sst = 0;
        end else begin
            m_alm   = {m_ah, m_al};
            m_old   = m_cnt;
            m_stepv = src_sel ? 64'(m_sb) : 64'(m_sa);
            m_nxt   = m_old + m_stepv;
            m_adv   = tick_en && !m_apply;
            m_cross = m_adv && m_ctrl[0] && (m_old < m_alm) && (m_nxt >= m_alm);
            if (m_apply) m_cnt = {m_sh, m_sl};
            else if (tick_en) m_cnt = m_nxt;
            if (m_sst == 1) m_snap = m_old;
            if (wr_en && addr == 4'h5 && wdata[0]) m_sst = 1;
            else if (m_sst == 1) m_sst = 2;
            if (m_cross) m_raw = 1;
            else if (wr_en && addr == 4'hA && wdata[0]) m_raw = 0;
            m_hit   = m_cross;
            m_apply = wr_en && addr == 4'h4 && wdata[0];
            if (wr_en) begin
                case (addr)
                    4'h0: m_ctrl = wdata[2:0];
                    4'h1: begin m_sa = wdata[7:0]; m_sb = wdata[15:8]; end
                    4'h2: m_sl = wdata;
                    4'h3: m_sh = wdata;
                    4'h8: m_al = wdata;
                    4'h9: m_ah = wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic bit [31:0] exp_rd(input bit [3:0] a);
        case (a)
            4'h0: return {29'b0, m_ctrl};
            4'h1: return {16'b0, m_sb, m_sa};
            4'h2: return m_sl;
            4'h3: return m_sh;
            4'h5: return {31'b0, m_sst == 2};
            4'h6: return m_snap[31:0];
            4'h7: return m_snap[63:32];
            4'h8: return m_al;
            4'h9: return m_ah;
            4'hA: return {31'b0, m_raw};
            default: return 32'b0;
        endcase
    endfunction

    task automatic chk(input string t, input bit [31:0] act, input bit [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%0h actual=%h expected=%h", t, addr, act, exp);
        end
    endtask

    task automatic compare();
        bit e_irq;
        e_irq = m_ctrl[2] && (m_ctrl[1] ? m_raw : m_hit);
        chk(tag, rdata, exp_rd(addr));
        chk(m_ctrl[1] ? "R8 irq" : "R9 irq", {31'b0, irq}, {31'b0, e_irq});
    endtask

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            compare();
        end
    endtask

    task automatic wr(input bit [3:0] a, input bit [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic snapshot();
        wr(4'h5, 32'h1);
        addr = 4'h5; cyc(2);
        addr = 4'h6; cyc();
        addr = 4'h7; cyc();
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #23;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        tag = "R1";
        addr = 4'h1; #1 chk("R1 steps", rdata, 32'h0000_0201);
        addr = 4'h5; #1 chk("R1 valid", rdata, 32'h0);
        addr = 4'hA; #1 chk("R1 raw", rdata, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        addr = 4'h0; cyc(2);
        // R2 count with both steps and idle
        tag = "R2";
        tick_en = 1'b1; src_sel = 1'b0; cyc(20);
        snapshot();
        src_sel = 1'b1; cyc(13);
        snapshot();
        tick_en = 1'b0; cyc(5);
        snapshot();
        tag = "R10";
        wr(4'h1, 32'h0000_0705); addr = 4'h1; cyc();
        tick_en = 1'b1; src_sel = 1'b0; cyc(4); src_sel = 1'b1; cyc(4);
        tag = "R2";
        snapshot();
        // R3 load across word boundary with tick running
        tag = "R3";
        wr(4'h1, 32'h0000_0201);
        wr(4'h2, 32'hFFFF_FFF0); wr(4'h3, 32'h0000_0001);
        src_sel = 1'b0;
        wr(4'h4, 32'h1);
        cyc(3);
        snapshot();
        cyc(20);
        snapshot();
        // R4 snapshot frozen while counting
        tag = "R4";
        addr = 4'h6; cyc(10);
        snapshot(); addr = 4'h5; cyc(3);
        // R5 + R8 level alarm crossing
        tag = "R5";
        wr(4'h8, m_cnt[31:0] + 32'd25); wr(4'h9, m_cnt[63:32]);
        wr(4'h0, 32'h7);
        addr = 4'hA; cyc(30);
        tag = "R7";
        wr(4'hA, 32'h1); addr = 4'hA; cyc(3);
        // R9 edge mode, step skips exact alarm
        tag = "R9";
        wr(4'h1, 32'h0000_0203);
        wr(4'h8, m_cnt[31:0] + 32'd17); wr(4'h9, m_cnt[63:32]);
        wr(4'h0, 32'h5);
        addr = 4'hA; cyc(15);
        wr(4'hA, 32'h1); cyc(2);
        // R6 alarm disabled
        tag = "R6";
        wr(4'h8, m_cnt[31:0] + 32'd12); wr(4'h9, m_cnt[63:32]);
        wr(4'h0, 32'h6);
        addr = 4'hA; cyc(20);
        // R7 raw with interrupt disabled
        tag = "R7";
        wr(4'h8, m_cnt[31:0] + 32'd12); wr(4'h9, m_cnt[63:32]);
        wr(4'h0, 32'h3);
        addr = 4'hA; cyc(20);
        wr(4'h0, 32'h7); cyc(2);
        wr(4'hA, 32'h1); addr = 4'hA; cyc(2);
        // R10 readback
        tag = "R10";
        wr(4'h2, 32'hA5A5_1234); addr = 4'h2; cyc();
        wr(4'h9, 32'h0F0F_0F0F); addr = 4'h9; cyc();
        addr = 4'h4; cyc();
        tick_en = 1'b0;
        cyc(3);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule